// File: doc/BRIEF.md
# Per-Block Write Mode Router

This block sits between the translation layer of a flash controller and its command sequencer. Every request names an operation (read, write or erase), a source tag (host or background), a physical block and a page. The block turns each accepted request into exactly one flash command. The command carries the program or read variant to use and the error-correction path that the data must take.

A one-bit mode table, with one entry per physical block, records how each block was programmed. The first write into a block fixes its mode from the source tag. Host traffic gets the fast program with relaxed retention, protected only by the outer BCH code. Background traffic (cleaning, wear-leveling, internal moves) gets the normal program, protected by the inner LDPC code and then the outer BCH code. Each block also has a written flag. Later writes reuse the stored mode and flag any disagreement with their tag. Reads decode according to the stored mode. Erase returns a block to normal and unwritten.

Both sides use valid/ready. A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is high whenever the single command register is empty or is being drained in the same cycle. While `cmd_valid` is high and `cmd_ready` is low, the command outputs hold steady and no request is accepted. Requests complete strictly in order.

Top module: `wmode_router`

## Requirements
- R1: A write to an unwritten block with source 0 (host) emits kind 1 (relaxed program) and ecc 1 (BCH only), and stores mode 1 (relaxed) for that block.
- R2: A write to an unwritten block with source 1 (background) emits kind 0 (normal program) and ecc 2 (LDPC then BCH), and stores mode 0 (normal).
- R3: Any write to a block that is already written, on any page including page 0, ignores the source tag. It emits the program kind and ecc that match the stored mode.
- R4: `cmd_mismatch` is 1 on a write to a written block whose source tag implies the other mode. It is 0 for every other command.
- R5: A read (op 0; reserved op 3 behaves as a read) emits kind 3 with ecc 1 for a relaxed block. It emits kind 2 with ecc 2 for a normal or unwritten block.
- R6: An erase (op 2) emits kind 4 with ecc 0, and returns the block to normal and unwritten, so the next write takes its mode from its source tag again.
- R7: After reset, every block is normal and unwritten, `cmd_valid` is 0 and `req_ready` is 1.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `req_ready` is 0 and the command outputs stay stable. Each accepted request produces one command on the next cycle.
- R9: Table entries are independent: an operation on one block never changes the mode seen for another block.
- R10: `cmd_blk` and `cmd_page` repeat the block and page of the request that produced the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 read |
| req_src | input | 1 | 0 host, 1 background |
| req_blk | input | BLK_W (6) | Physical block number |
| req_page | input | PAGE_W (4) | Page within the block |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_kind | output | 3 | 0 normal program, 1 relaxed program, 2 normal read, 3 relaxed read, 4 erase |
| cmd_ecc | output | 2 | 0 none, 1 BCH only, 2 LDPC and BCH |
| cmd_blk | output | BLK_W (6) | Block of the command |
| cmd_page | output | PAGE_W (4) | Page of the command |
| cmd_mismatch | output | 1 | Source tag disagreed with stored mode |

## Verification
The first writes to fresh blocks are tried with both source tags. This separates the two program and encode choices. Follow-up writes then use the opposite tag on page 0 and on later pages, which shows that the stored mode wins and that the mismatch flag rises only on a real disagreement. Reads of relaxed, normal, never-written and just-erased blocks separate the lookup from its reset default. Blocks 0, 62 and 63 check that entries do not alias, and a stalled sequencer checks the hold and back-pressure rules.

// File: rtl/wmode_pkg.sv
package wmode_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    K_PROG_NORM = 3'd0,
    K_PROG_FAST = 3'd1,
    K_READ_NORM = 3'd2,
    K_READ_FAST = 3'd3,
    K_ERASE     = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    ECC_NONE  = 2'd0,
    ECC_OUTER = 2'd1,
    ECC_BOTH  = 2'd2
  } ecc_e;

  localparam logic SRC_HOST = 1'b0;
  localparam logic MODE_FAST = 1'b1;
endpackage

// File: rtl/wmode_table.sv
module wmode_table #(
  parameter int NBLK  = 64,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_mode,
  output logic             rd_written,
  input  logic             upd_en,
  input  logic             upd_clear,
  input  logic             upd_mode,
  input  logic [BLK_W-1:0] upd_blk
);
  logic [NBLK-1:0] mode_q;
  logic [NBLK-1:0] wr_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[g] <= 1'b0;
        wr_q[g]   <= 1'b0;
      end else if (upd_en && upd_blk == BLK_W'(g)) begin
        mode_q[g] <= upd_clear ? 1'b0 : upd_mode;
        wr_q[g]   <= !upd_clear;
      end
    end
  end

  assign rd_mode    = mode_q[rd_blk];
  assign rd_written = wr_q[rd_blk];

  // R6: a clear leaves the entry normal and unwritten
  p_clear_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_clear |=> !wr_q[$past(upd_blk)] && !mode_q[$past(upd_blk)]);

  // R9: at most the addressed entry changes in one cycle
  p_one_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_q ^ $past(wr_q)) <= 1);
endmodule

// File: rtl/wmode_decide.sv
module wmode_decide
  import wmode_pkg::*;
(
  input  logic [1:0] op,
  input  logic       src,
  input  logic       cur_mode,
  input  logic       cur_written,
  output logic [2:0] kind,
  output logic [1:0] ecc,
  output logic       mismatch,
  output logic       upd_en,
  output logic       upd_clear,
  output logic       upd_mode
);
  logic tag_mode;
  logic use_mode;

  assign tag_mode = (src == SRC_HOST) ? MODE_FAST : 1'b0;
  assign use_mode = cur_written ? cur_mode : tag_mode;

  always_comb begin
    kind      = K_READ_NORM;
    ecc       = ECC_BOTH;
    mismatch  = 1'b0;
    upd_en    = 1'b0;
    upd_clear = 1'b0;
    upd_mode  = 1'b0;
    unique case (op_e'(op))
      OP_WRITE: begin
        kind     = use_mode ? K_PROG_FAST : K_PROG_NORM;
        ecc      = use_mode ? ECC_OUTER : ECC_BOTH;
        mismatch = cur_written && (cur_mode != tag_mode);
        upd_en   = !cur_written;
        upd_mode = tag_mode;
      end
      OP_ERASE: begin
        kind      = K_ERASE;
        ecc       = ECC_NONE;
        upd_en    = 1'b1;
        upd_clear = 1'b1;
      end
      OP_READ, OP_RSVD: begin
        kind = cur_mode ? K_READ_FAST : K_READ_NORM;
        ecc  = cur_mode ? ECC_OUTER : ECC_BOTH;
      end
    endcase
  end

  // R5: a read never writes the table
  always_comb begin
    if (op_e'(op) == OP_READ) a_read_no_upd_r5: assert (!upd_en);
  end
endmodule

// File: rtl/wmode_router.sv
module wmode_router
  import wmode_pkg::*;
#(
  parameter int NBLK   = 64,
  parameter int PAGE_W = 4,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_src,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [PAGE_W-1:0] req_page,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_kind,
  output logic [1:0]        cmd_ecc,
  output logic [BLK_W-1:0]  cmd_blk,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              cmd_mismatch
);
  logic       accept;
  logic       t_mode, t_written;
  logic [2:0] d_kind;
  logic [1:0] d_ecc;
  logic       d_mis, d_upd, d_clr, d_mode;

  assign req_ready = !cmd_valid || cmd_ready;
  assign accept    = req_valid && req_ready;

  wmode_table #(.NBLK(NBLK), .BLK_W(BLK_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_mode(t_mode), .rd_written(t_written),
    .upd_en(accept && d_upd), .upd_clear(d_clr), .upd_mode(d_mode),
    .upd_blk(req_blk)
  );

  wmode_decide decide_i (
    .op(req_op), .src(req_src),
    .cur_mode(t_mode), .cur_written(t_written),
    .kind(d_kind), .ecc(d_ecc), .mismatch(d_mis),
    .upd_en(d_upd), .upd_clear(d_clr), .upd_mode(d_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid    <= 1'b0;
      cmd_kind     <= 3'd0;
      cmd_ecc      <= 2'd0;
      cmd_blk      <= '0;
      cmd_page     <= '0;
      cmd_mismatch <= 1'b0;
    end else if (accept) begin
      cmd_valid    <= 1'b1;
      cmd_kind     <= d_kind;
      cmd_ecc      <= d_ecc;
      cmd_blk      <= req_blk;
      cmd_page     <= req_page;
      cmd_mismatch <= d_mis;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R8: a stalled command holds all fields
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_ecc)
      && $stable(cmd_blk) && $stable(cmd_page) && $stable(cmd_mismatch));

  // R8: every accepted request yields a command next cycle
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd_valid);

  // R4: mismatch only accompanies program commands
  p_mis_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_mismatch |-> cmd_kind <= 3'd1);

  // R10: the command echoes the accepted address
  p_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd_blk == $past(req_blk) && cmd_page == $past(req_page));
endmodule

// File: tb/wmode_router_tb.sv
module wmode_router_tb_top;
  localparam int BLK_W = 6;
  localparam int PW = 4;
  localparam int NV = 15;
  // {op, src, blk, page, kind, ecc, mismatch}
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 1'b0, 6'd5,  4'd0, 3'd1, 2'd1, 1'b0},  // R1
    {2'd1, 1'b1, 6'd9,  4'd0, 3'd0, 2'd2, 1'b0},  // R2
    {2'd1, 1'b0, 6'd5,  4'd1, 3'd1, 2'd1, 1'b0},  // R3
    {2'd1, 1'b1, 6'd5,  4'd2, 3'd1, 2'd1, 1'b1},  // R3 R4
    {2'd1, 1'b0, 6'd9,  4'd3, 3'd0, 2'd2, 1'b1},  // R4
    {2'd0, 1'b0, 6'd5,  4'd0, 3'd3, 2'd1, 1'b0},  // R5
    {2'd0, 1'b1, 6'd9,  4'd7, 3'd2, 2'd2, 1'b0},  // R5
    {2'd3, 1'b0, 6'd20, 4'd0, 3'd2, 2'd2, 1'b0},  // R5 unwritten
    {2'd2, 1'b0, 6'd5,  4'd0, 3'd4, 2'd0, 1'b0},  // R6
    {2'd0, 1'b0, 6'd5,  4'd0, 3'd2, 2'd2, 1'b0},  // R6
    {2'd1, 1'b1, 6'd5,  4'd4, 3'd0, 2'd2, 1'b0},  // R6
    {2'd1, 1'b0, 6'd63, 4'd0, 3'd1, 2'd1, 1'b0},  // R9
    {2'd0, 1'b0, 6'd62, 4'd0, 3'd2, 2'd2, 1'b0},  // R9
    {2'd0, 1'b0, 6'd63, 4'd9, 3'd3, 2'd1, 1'b0},  // R9
    {2'd1, 1'b0, 6'd5,  4'd0, 3'd0, 2'd2, 1'b1}   // R3 page 0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_src = 1'b0, cmd_ready = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic [BLK_W-1:0] req_blk = '0;
  logic [PW-1:0] req_page = '0;
  logic req_ready, cmd_valid, cmd_mismatch;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_ecc;
  logic [BLK_W-1:0] cmd_blk;
  logic [PW-1:0] cmd_page;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;

  wmode_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_blk(req_blk), .req_page(req_page),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_ecc(cmd_ecc), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .cmd_mismatch(cmd_mismatch)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  // drive at negedge, accept at posedge, sample at following negedge
  task automatic issue(input logic [1:0] op, input logic src,
                       input logic [BLK_W-1:0] blk, input logic [PW-1:0] pg);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = src; req_blk = blk; req_page = pg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 cmd_valid", int'(cmd_valid), 0);
    chk("R7 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    issue(2'd0, 1'b0, 6'd0, 4'd0);
    chk("R7 read blk0 kind", int'(cmd_kind), 2);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      issue(v[18:17], v[16], v[15:10], v[9:6]);
      chk($sformatf("R1-vec%0d kind", i), int'(cmd_kind), int'(v[5:3]));
      chk($sformatf("R2-vec%0d ecc", i), int'(cmd_ecc), int'(v[2:1]));
      chk($sformatf("R4 vec%0d mismatch", i), int'(cmd_mismatch), int'(v[0]));
      chk($sformatf("R10 vec%0d blk", i), int'(cmd_blk), int'(v[15:10]));
      chk($sformatf("R10 vec%0d page", i), int'(cmd_page), int'(v[9:6]));
      chk($sformatf("R8 vec%0d valid", i), int'(cmd_valid), 1);
    end

    // R8 back-pressure
    @(negedge clk);
    cmd_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd0; req_src = 1'b0; req_blk = 6'd63; req_page = 4'd2;
    @(negedge clk);
    chk("R8 first held kind", int'(cmd_kind), 3);
    chk("R8 ready low", int'(req_ready), 0);
    req_op = 2'd1; req_src = 1'b1; req_blk = 6'd40; req_page = 4'd0;
    repeat (3) @(negedge clk);
    chk("R8 stall blk", int'(cmd_blk), 63);
    chk("R8 stall page", int'(cmd_page), 2);
    chk("R8 stall ready", int'(req_ready), 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second kind", int'(cmd_kind), 0);
    chk("R8 second blk", int'(cmd_blk), 40);
    @(negedge clk);
    chk("R8 drained", int'(cmd_valid), 0);

    // R4: stalled write stored background mode for blk 40
    issue(2'd1, 1'b0, 6'd40, 4'd1);
    chk("R4 blk40 host mismatch", int'(cmd_mismatch), 1);
    chk("R3 blk40 kind", int'(cmd_kind), 0);

    // R7: reset again clears table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 reset valid", int'(cmd_valid), 0);
    rst_n = 1'b1;
    issue(2'd0, 1'b0, 6'd63, 4'd0);
    chk("R7 blk63 normal after reset", int'(cmd_kind), 2);
    issue(2'd1, 1'b0, 6'd40, 4'd0);
    chk("R7 blk40 unwritten after reset", int'(cmd_kind), 1);
    chk("R7 no mismatch", int'(cmd_mismatch), 0);

    finish_run();
  end
endmodule